// File: doc/BRIEF.md
# Bayer Line-Pair Output Formatter

This block turns raw Bayer rows into a video output stream on two byte-wide channels, a primary channel (Y) and a secondary channel (UV). An upstream line store holds one row of blue/green samples and one row of green/red samples. The formatter addresses both rows by column through `rd_col` and asks for a row pair through `row_pair`. It then places the samples on the channels in the order the selected format requires. It produces a line-valid strobe (`href`) and a pixel strobe (`pclk_en`). Both are expressed as enables in the core clock domain.

A frame is started by a one-cycle `frame_start` pulse, which also loads the format selection. The frame then runs through `LINES` line periods and goes idle. The first line period of a frame is dark, except in single-row format, so that each row pair appears on two consecutive lines. A channel that a format does not use has its output enable low and its data held at zero.

Top module: `bayer_line_fmt`

## Requirements
- R1: While `rst_n` is low and after its release, `href`, `pclk_en` and `uv_oe` are low and `y_out` and `uv_out` are zero until a frame is started.
- R2: A `frame_start` pulse (re)starts a frame at line 0, slot 0, even when a frame is in progress. A frame is `LINES` line periods of `2*COLS` active slots followed by `BLANK` blank slots, and then all outputs return to the idle state of R1. Each output lags its slot by one clock.
- R3: In formats 0, 1 and 3, line 0 of a frame is dark: `href` stays low and the data stays zero. In format 2, line 0 carries data.
- R4: In formats 0, 1 and 3, line L≥1 uses row pair (L-1)/2, so each pair is sent on two consecutive lines. In format 2, line L uses pair L/2 and sends the blue/green row when L is even and the green/red row when L is odd.
- R5: Format 0 (dual): for column c = slot/2, Y carries the green/red sample and UV carries the blue/green sample.
- R6: Format 1 (green-on-Y): in even columns, Y takes the green/red row (green) and UV takes the blue/green row (blue). In odd columns, Y takes the blue/green row (green) and UV takes the green/red row (red).
- R7: Format 2 (single-row): Y carries the row selected by R4, and UV is disabled.
- R8: Format 3 (byte): each slot yields one Y sample, so `pclk_en` is high on every active slot. For slot s, the order within each group of four slots (s mod 4 = 0,1,2,3) is blue/green, green/red, green/red, blue/green, at column s/2. UV is disabled.
- R9: In formats 0, 1 and 2, each column occupies two slots with the data held across both, and `pclk_en` is high only on the odd slot.
- R10: `href` is high exactly during the active slots of a non-dark line. Whenever `href` is low, `y_out`, `uv_out` and `pclk_en` are zero.
- R11: `mode_sel` is sampled only on `frame_start`. A change of `mode_sel` during a frame has no effect on that frame.
- R12: `uv_oe` is high for the whole run of a frame in formats 0 and 1, and is low otherwise. While it is low, `uv_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame start; loads the format |
| mode_sel | input | 2 | Format: 0 dual, 1 green-on-Y, 2 single-row, 3 byte |
| bg_pix | input | 8 | Blue/green row sample at `rd_col` |
| gr_pix | input | 8 | Green/red row sample at `rd_col` |
| row_pair | output | $clog2(LINES) | Row pair index requested from the line store |
| rd_col | output | $clog2(COLS) | Column being read from both rows |
| href | output | 1 | Line valid, high only on valid pixels |
| pclk_en | output | 1 | Pixel strobe; data is stable while high |
| y_out | output | 8 | Primary channel data |
| uv_out | output | 8 | Secondary channel data |
| uv_oe | output | 1 | Secondary channel output enable |

## Verification
A wrong line or slot counter shows up at the ports within one line period. Either `href` rises in the wrong clock, or the sample from the wrong row pair appears on Y one clock after the bad addressing. A mode register that is loaded at the wrong time changes the sample order or the `uv_oe` level on the very next output cycle. The bench therefore compares every output on every clock of whole frames in each format, and also around a mid-frame format change and a mid-frame restart.

// File: rtl/bayer_fmt_pkg.sv
package bayer_fmt_pkg;

  typedef enum logic [1:0] {
    FMT_DUAL   = 2'd0,
    FMT_GREEN  = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_BYTE   = 2'd3
  } fmt_mode_e;

  // Secondary channel is driven only in the two-channel formats.
  function automatic logic fmt_dual_chan(fmt_mode_e m);
    return (m == FMT_DUAL) || (m == FMT_GREEN);
  endfunction

  // Line 0 is dark in every format except single-row.
  function automatic logic fmt_line_shown(fmt_mode_e m, logic first_line);
    return (m == FMT_SINGLE) || !first_line;
  endfunction

  // Pixel strobe: byte format every slot, otherwise odd slot of a column.
  function automatic logic fmt_strobe(fmt_mode_e m, logic slot_odd);
    return (m == FMT_BYTE) || slot_odd;
  endfunction

  // Primary channel sample; ph = slot[1:0], ph[1] is the column parity.
  function automatic logic [7:0] fmt_pick_y(fmt_mode_e m, logic [1:0] ph,
                                            logic line_odd,
                                            logic [7:0] bg, logic [7:0] gr);
    case (m)
      FMT_DUAL:   return gr;
      FMT_GREEN:  return ph[1] ? bg : gr;
      FMT_SINGLE: return line_odd ? gr : bg;
      default:    return (ph == 2'd1 || ph == 2'd2) ? gr : bg;
    endcase
  endfunction

  // Secondary channel sample.
  function automatic logic [7:0] fmt_pick_uv(fmt_mode_e m, logic [1:0] ph,
                                             logic [7:0] bg, logic [7:0] gr);
    case (m)
      FMT_DUAL:  return bg;
      FMT_GREEN: return ph[1] ? gr : bg;
      default:   return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/fmt_timing.sv
module fmt_timing
  import bayer_fmt_pkg::*;
#(
  parameter int COLS  = 352,
  parameter int BLANK = 64,
  parameter int LINES = 292,
  localparam int LINE_LEN = 2 * COLS + BLANK,
  localparam int SLOT_W   = $clog2(LINE_LEN),
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  fmt_mode_e         mode_in,
  output logic              run,
  output fmt_mode_e         mode_q,
  output logic [LINE_W-1:0] line_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              active
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LINE_LEN - 1);
  localparam logic [SLOT_W-1:0] ACT_END   = SLOT_W'(2 * COLS);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic slot_wrap;
  logic frame_done;

  assign slot_wrap  = (slot_cnt == SLOT_LAST);
  assign frame_done = slot_wrap && (line_cnt == LINE_LAST);
  assign active     = run && (slot_cnt < ACT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      mode_q   <= FMT_DUAL;
      line_cnt <= '0;
      slot_cnt <= '0;
    end else if (frame_start) begin
      run      <= 1'b1;
      mode_q   <= mode_in;
      line_cnt <= '0;
      slot_cnt <= '0;
    end else if (run) begin
      if (slot_wrap) begin
        slot_cnt <= '0;
        line_cnt <= frame_done ? '0 : line_cnt + 1'b1;
        if (frame_done) run <= 1'b0;
      end else begin
        slot_cnt <= slot_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fmt_addr.sv
module fmt_addr
  import bayer_fmt_pkg::*;
#(
  parameter int COLS  = 352,
  parameter int BLANK = 64,
  parameter int LINES = 292,
  localparam int LINE_LEN = 2 * COLS + BLANK,
  localparam int SLOT_W   = $clog2(LINE_LEN),
  localparam int LINE_W   = $clog2(LINES),
  localparam int COL_W    = $clog2(COLS)
) (
  input  fmt_mode_e         mode_q,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [SLOT_W-1:0] slot_cnt,
  output logic [LINE_W-1:0] row_pair,
  output logic [COL_W-1:0]  rd_col
);
  logic [LINE_W-1:0] line_back;

  assign line_back = (line_cnt == '0) ? '0 : line_cnt - 1'b1;
  assign rd_col    = slot_cnt[COL_W:1];

  always_comb begin
    if (mode_q == FMT_SINGLE) row_pair = line_cnt >> 1;
    else                      row_pair = line_back >> 1;
  end

endmodule

// File: rtl/fmt_outreg.sv
module fmt_outreg
  import bayer_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  fmt_mode_e  mode_q,
  input  logic       shown,
  input  logic [1:0] phase,
  input  logic       line_odd,
  input  logic [7:0] bg_pix,
  input  logic [7:0] gr_pix,
  output logic       href,
  output logic       pclk_en,
  output logic [7:0] y_out,
  output logic [7:0] uv_out,
  output logic       uv_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      href    <= 1'b0;
      pclk_en <= 1'b0;
      y_out   <= '0;
      uv_out  <= '0;
      uv_oe   <= 1'b0;
    end else begin
      href    <= shown;
      pclk_en <= shown && fmt_strobe(mode_q, phase[0]);
      y_out   <= shown ? fmt_pick_y(mode_q, phase, line_odd, bg_pix, gr_pix) : 8'd0;
      uv_out  <= shown ? fmt_pick_uv(mode_q, phase, bg_pix, gr_pix) : 8'd0;
      uv_oe   <= run && fmt_dual_chan(mode_q);
    end
  end

endmodule

// File: rtl/bayer_line_fmt.sv
module bayer_line_fmt
  import bayer_fmt_pkg::*;
#(
  parameter int COLS  = 352,
  parameter int BLANK = 64,
  parameter int LINES = 292,
  localparam int LINE_LEN = 2 * COLS + BLANK,
  localparam int SLOT_W   = $clog2(LINE_LEN),
  localparam int LINE_W   = $clog2(LINES),
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        mode_sel,
  input  logic [7:0]        bg_pix,
  input  logic [7:0]        gr_pix,
  output logic [LINE_W-1:0] row_pair,
  output logic [COL_W-1:0]  rd_col,
  output logic              href,
  output logic              pclk_en,
  output logic [7:0]        y_out,
  output logic [7:0]        uv_out,
  output logic              uv_oe
);
  // Named internal events, observed by the bound checker.
  logic              run;
  fmt_mode_e         cur_mode;
  logic [LINE_W-1:0] line_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic              active;
  logic              line_shown;

  fmt_timing #(.COLS(COLS), .BLANK(BLANK), .LINES(LINES)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_in     (fmt_mode_e'(mode_sel)),
    .run         (run),
    .mode_q      (cur_mode),
    .line_cnt    (line_cnt),
    .slot_cnt    (slot_cnt),
    .active      (active)
  );

  fmt_addr #(.COLS(COLS), .BLANK(BLANK), .LINES(LINES)) u_addr (
    .mode_q   (cur_mode),
    .line_cnt (line_cnt),
    .slot_cnt (slot_cnt),
    .row_pair (row_pair),
    .rd_col   (rd_col)
  );

  assign line_shown = active && fmt_line_shown(cur_mode, line_cnt == '0);

  fmt_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mode_q   (cur_mode),
    .shown    (line_shown),
    .phase    (slot_cnt[1:0]),
    .line_odd (line_cnt[0]),
    .bg_pix   (bg_pix),
    .gr_pix   (gr_pix),
    .href     (href),
    .pclk_en  (pclk_en),
    .y_out    (y_out),
    .uv_out   (uv_out),
    .uv_oe    (uv_oe)
  );

endmodule

// File: rtl/bayer_line_fmt_chk.sv
module bayer_line_fmt_chk #(
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [1:0]        cur_mode,
  input logic              run,
  input logic [LINE_W-1:0] line_cnt,
  input logic              href,
  input logic              pclk_en,
  input logic [7:0]        y_out,
  input logic [7:0]        uv_out,
  input logic              uv_oe
);
  AST_UV_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_oe |-> uv_out == 8'd0); // R12
  AST_DARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !href |-> (y_out == 8'd0 && uv_out == 8'd0 && !pclk_en)); // R10
  AST_FIRST_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_cnt == '0 && cur_mode != 2'd2) |=> !href); // R3
  AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (href && $past(cur_mode) == 2'd3) |-> pclk_en); // R8
  AST_WORD_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en && $past(cur_mode) != 2'd3) |=> !pclk_en); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_mode)); // R11
endmodule

bind bayer_line_fmt bayer_line_fmt_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .cur_mode    (cur_mode),
  .run         (run),
  .line_cnt    (line_cnt),
  .href        (href),
  .pclk_en     (pclk_en),
  .y_out       (y_out),
  .uv_out      (uv_out),
  .uv_oe       (uv_oe)
);

// File: tb/tb_bayer_line_fmt.sv
`timescale 1ns/1ps
module tb_bayer_line_fmt;
  localparam int COLS  = 4;
  localparam int BLANK = 3;
  localparam int LINES = 6;
  localparam int LL    = 2 * COLS + BLANK;
  localparam int TOTAL = LINES * LL;
  localparam int LW    = $clog2(LINES);
  localparam int CW    = $clog2(COLS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [1:0]    mode_sel = 2'd0;
  logic [7:0]    bg_pix, gr_pix;
  logic [LW-1:0] row_pair;
  logic [CW-1:0] rd_col;
  logic          href, pclk_en, uv_oe;
  logic [7:0]    y_out, uv_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bayer_line_fmt #(.COLS(COLS), .BLANK(BLANK), .LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
    .bg_pix(bg_pix), .gr_pix(gr_pix), .row_pair(row_pair), .rd_col(rd_col),
    .href(href), .pclk_en(pclk_en), .y_out(y_out), .uv_out(uv_out), .uv_oe(uv_oe)
  );

  // Line-store model: a distinct value per (pair, column, row).
  function automatic logic [7:0] pix(int pair, int col, int row);
    return 8'((pair * 8) + (col * 2) + row + 1);
  endfunction

  always_comb begin
    bg_pix = pix(int'(row_pair), int'(rd_col), 0);
    gr_pix = pix(int'(row_pair), int'(rd_col), 1);
  end

  // Compare all outputs against the expected set; FAIL line on mismatch.
  task automatic cmp(string tag, logic eh, logic ep, logic [7:0] ey,
                     logic [7:0] eu, logic eo);
    checks++;
    if (href !== eh || pclk_en !== ep || y_out !== ey || uv_out !== eu || uv_oe !== eo) begin
      errors++;
      $display("FAIL %s: got href=%b pclk=%b y=%h uv=%h oe=%b, expected href=%b pclk=%b y=%h uv=%h oe=%b",
               tag, href, pclk_en, y_out, uv_out, uv_oe, eh, ep, ey, eu, eo);
    end
  endtask

  // Expected outputs for (format, line, slot), restated from the requirements.
  task automatic expect_at(int m, int ln, int s, string extra);
    logic eh, ep, eo;
    logic [7:0] ey, eu;
    int col, pair, bg, gr;
    string tag;
    bit first_dark;
    col  = s / 2;
    pair = (m == 2) ? ln / 2 : (ln == 0 ? 0 : (ln - 1) / 2);
    bg   = pix(pair, col, 0);
    gr   = pix(pair, col, 1);
    first_dark = (m != 2) && (ln == 0);
    eh = (s < 2 * COLS) && !first_dark;
    eo = (m == 0 || m == 1);
    ep = eh && ((m == 3) || (s % 2 == 1));
    ey = 8'd0;
    eu = 8'd0;
    if (eh) begin
      case (m)
        0: begin ey = 8'(gr); eu = 8'(bg); end                                     // R5
        1: begin ey = (col % 2 == 0) ? 8'(gr) : 8'(bg);
                 eu = (col % 2 == 0) ? 8'(bg) : 8'(gr); end                        // R6
        2: ey = (ln % 2 == 1) ? 8'(gr) : 8'(bg);                                   // R7
        default: ey = (s % 4 == 1 || s % 4 == 2) ? 8'(gr) : 8'(bg);                // R8
      endcase
    end
    if (first_dark)              tag = "R3";
    else if (!eh)                tag = "R10";
    else if (m == 0)             tag = "R5 R9";
    else if (m == 1)             tag = "R6 R9";
    else if (m == 2)             tag = "R7 R9";
    else                         tag = "R8";
    if (ln >= 2) tag = {tag, " R4"};
    tag = {tag, " R12", extra};
    cmp(tag, eh, ep, ey, eu, eo);
  endtask

  // Pulse frame_start at the current negedge; returns one negedge later.
  task automatic start_frame(int m);
    frame_start = 1'b1;
    mode_sel    = 2'(m);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Check n cycles of a frame in format m from its first slot.
  task automatic check_span(int m, int n, string extra, output int rises);
    logic prev;
    prev  = 1'b0;
    rises = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      expect_at(m, k / LL, k % LL, extra);
      if (href && !prev) rises++;
      prev = href;
    end
  endtask

  task automatic check_idle(string tag);
    cmp(tag, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0);
  endtask

  // R1: reset state.
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");
  endtask

  // Whole frame in one format, then idle (R2) and line count (R2, R3).
  task automatic t_full_frame(int m);
    int rises;
    start_frame(m);
    check_span(m, TOTAL, "", rises);
    @(negedge clk);
    check_idle("R2 frame end");
    repeat (4) @(negedge clk);
    check_idle("R2 stays idle");
    checks++;
    if (rises != ((m == 2) ? LINES : LINES - 1)) begin
      errors++;
      $display("FAIL R2 R3 line count: got %0d expected %0d", rises,
               (m == 2) ? LINES : LINES - 1);
    end
  endtask

  // R11: format input changes during the frame and has no effect.
  task automatic t_mode_change(int m, int other);
    int rises;
    frame_start = 1'b1;
    mode_sel    = 2'(m);
    @(negedge clk);
    frame_start = 1'b0;
    mode_sel    = 2'(other);
    check_span(m, TOTAL, " R11", rises);
    @(negedge clk);
    check_idle("R11 R2 frame end");
  endtask

  // R2: restart in the middle of a frame with another format.
  task automatic t_restart();
    int rises;
    start_frame(0);
    check_span(0, 2 * LL + 5, "", rises);
    start_frame(3);
    check_span(3, TOTAL, " R2 restart", rises);
    @(negedge clk);
    check_idle("R2 restart end");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_frame(0);
    t_full_frame(1);
    t_full_frame(2);
    t_full_frame(3);
    t_mode_change(1, 3);
    t_mode_change(2, 0);
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule